// File: doc/BRIEF.md
# Audio frame sequencer with interrupt

This block paces the slow clocks of a sound unit. Each clock cycle of the block is one CPU cycle. An internal signed counter counts these cycles. At six fixed boundaries per frame, one per step, it emits quarter-frame and half-frame pulses that drive the envelope, sweep and length units downstream. Two boundary tables are available, one per video region. Two sequence lengths are available: a short 4-step frame and a long 5-step frame.

Software writes a control byte. Bit 7 of that byte picks the sequence length and bit 6 masks the frame interrupt. Each write restarts the sequence after a short delay. The delay depends on whether the write lands on an odd or an even CPU cycle. In the short mode, the frame interrupt is raised on the last three boundaries and stays high until it is acknowledged, masked or reset. The region is taken only at reset, so the table never changes within a frame.

Top module: `frame_sequencer`

## Requirements
- R1: After a hard reset (rst high with soft_rst low), the mode is 4-step and the interrupt is unmasked. All three outputs are low. The counter holds 6, so boundary B fires its event B-5 cycles after the last reset cycle.
- R2: With region_pal low at reset, the boundaries in 4-step mode are 7457, 14913, 22371, 29828, 29829 and 29830. In 5-step mode they are 7457, 14913, 22371, 29829, 37281 and 37282.
- R3: With region_pal high at reset, the boundaries in 4-step mode are 8313, 16627, 24939, 33252, 33253 and 33254. In 5-step mode they are 8313, 16627, 24939, 33253, 41565 and 41566. region_pal is sampled only in reset cycles.
- R4: Step indices 0 to 5 carry these events in this order: quarter, half, quarter, none, half, none. A quarter event raises qtr_pulse alone for one cycle. A half event raises both qtr_pulse and half_pulse for one cycle.
- R5: When the step 5 boundary fires, the counter and the step index return to 0. The next frame's first boundary b0 therefore fires b0+1 cycles after the step 5 event.
- R6: A write (wr_en high) sets 5-step mode when wr_data[7] is 1 and 4-step mode when it is 0. It resets the step index to 0 and loads the counter with -3 when cyc_odd is 1, or with -4 when cyc_odd is 0. Boundary B then fires B+4 or B+5 cycles after the write cycle. A boundary that falls on the write cycle is dropped.
- R7: A write with wr_data[7] set raises both qtr_pulse and half_pulse in the cycle after the write, whatever step the sequencer is in.
- R8: In 4-step mode with the interrupt unmasked, irq is set at the boundaries of steps 3, 4 and 5. Once set, it stays high.
- R9: A write with wr_data[6] set masks the interrupt and drives irq low in the next cycle. No further set happens until a write with wr_data[6] clear, or a reset.
- R10: A one-cycle irq_ack drives irq low in the next cycle, unless a set falls in the same cycle.
- R11: In 5-step mode irq is never set.
- R12: A soft reset (rst and soft_rst both high) keeps the selected mode. It clears the mask and irq, reloads the counter with 6, resets the step index and resamples region_pal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per CPU cycle |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | With rst, keeps the selected mode |
| region_pal | input | 1 | Region table select, sampled during reset (1 = longer table) |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: bit 7 = 5-step mode, bit 6 = interrupt mask |
| cyc_odd | input | 1 | Parity of the current CPU cycle, 1 = odd |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| qtr_pulse | output | 1 | One-cycle quarter-frame clock |
| half_pulse | output | 1 | One-cycle half-frame clock |
| irq | output | 1 | Frame interrupt level |

## Verification
The assertions check local rules on every cycle:
- the step index stays in range;
- the counter returns to zero on the final boundary;
- a write leaves step 0 and a negative count;
- a mode-5 write yields both pulses;
- a half pulse always carries a quarter pulse;
- a masking write drops irq;
- irq never rises while masked or in 5-step mode;
- a soft reset keeps the mode;
- the region is frozen outside reset.

Only the bench scenarios can show the absolute timing:
- the exact cycle of each of the six boundaries, in both regions and both modes;
- the parity-dependent start after a write;
- the wrap into the next frame;
- the point where the interrupt first rises.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int STEPS          = 6;
    localparam int IRQ_FIRST_STEP = 3;
    localparam int MAX_BOUND      = 41566;
    localparam int CNT_W          = $clog2(MAX_BOUND + 1) + 1;
    localparam int STEP_W         = $clog2(STEPS);

    typedef logic signed [CNT_W-1:0] cnt_t;
    typedef logic [STEP_W-1:0]       step_t;

    localparam step_t LAST_STEP = step_t'(STEPS - 1);

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_QTR  = 2'd1,
        EV_HALF = 2'd2
    } fev_e;

    typedef struct packed {
        logic five;
        logic inhibit;
        logic pal;
    } fcfg_t;

    // Boundary count of a step: the first three steps share the region
    // values, the tail depends on the sequence length.
    function automatic cnt_t step_bound(logic pal, logic five, step_t s);
        int b0, b1, b2, b3, b5, r;
        b0 = pal ? 8313  : 7457;
        b1 = pal ? 16627 : 14913;
        b2 = pal ? 24939 : 22371;
        b3 = pal ? 33252 : 29828;
        b5 = pal ? 41565 : 37281;
        if (int'(s) == 0)      r = b0;
        else if (int'(s) == 1) r = b1;
        else if (int'(s) == 2) r = b2;
        else if (int'(s) == 3) r = five ? b3 + 1 : b3;
        else if (int'(s) == 4) r = five ? b5 : b3 + 1;
        else                   r = five ? b5 + 1 : b3 + 2;
        return cnt_t'(r);
    endfunction

    function automatic fev_e step_event(step_t s);
        fev_e e;
        if (int'(s) == 1 || int'(s) == 4)      e = EV_HALF;
        else if (int'(s) == 0 || int'(s) == 2) e = EV_QTR;
        else                                   e = EV_NONE;
        return e;
    endfunction

    function automatic logic step_raises_irq(step_t s);
        return int'(s) >= IRQ_FIRST_STEP;
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MODE_BIT   = 7,
    parameter int INH_BIT    = 6,
    parameter int ODD_DELAY  = 3,
    parameter int EVEN_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              region_pal,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cyc_odd,
    output fcfg_t             cfg,
    output logic              restart,
    output cnt_t              restart_val,
    output logic              imm_clk,
    output logic              irq_clr
);

    localparam cnt_t ODD_LOAD  = -cnt_t'(ODD_DELAY);
    localparam cnt_t EVEN_LOAD = -cnt_t'(EVEN_DELAY);

    logic unused_data_bits;
    assign unused_data_bits = ^wr_data;

    fcfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.inhibit <= 1'b0;
            cfg_q.pal     <= region_pal;
            if (!soft_rst) begin
                cfg_q.five <= 1'b0;
            end
        end else if (wr_en) begin
            cfg_q.five    <= wr_data[MODE_BIT];
            cfg_q.inhibit <= wr_data[INH_BIT];
        end
    end

    always_comb begin
        cfg         = cfg_q;
        restart     = wr_en;
        restart_val = cyc_odd ? ODD_LOAD : EVEN_LOAD;
        imm_clk     = wr_en && wr_data[MODE_BIT];
        irq_clr     = wr_en && wr_data[INH_BIT];
    end

    // R12: a soft reset leaves the selected sequence length alone
    a_r12_soft_keep: assert property (@(posedge clk)
        (rst && soft_rst) |=> (cfg_q.five == $past(cfg_q.five)));

    // R3: the region select only moves in reset cycles
    a_r3_region_frozen: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> $stable(cfg_q.pal));

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import fseq_pkg::*;
#(
    parameter int POWERUP_CNT = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  fcfg_t cfg,
    input  logic  restart,
    input  cnt_t  restart_val,
    output logic  fire,
    output step_t step
);

    cnt_t  cnt_q;
    step_t step_q;
    logic  hit;

    always_comb begin
        hit  = (cnt_q == step_bound(cfg.pal, cfg.five, step_q));
        fire = hit && !restart;
        step = step_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= cnt_t'(POWERUP_CNT);
            step_q <= '0;
        end else if (restart) begin
            cnt_q  <= restart_val;
            step_q <= '0;
        end else if (hit && step_q == LAST_STEP) begin
            cnt_q  <= '0;
            step_q <= '0;
        end else if (hit) begin
            cnt_q  <= cnt_q + cnt_t'(1);
            step_q <= step_q + step_t'(1);
        end else begin
            cnt_q  <= cnt_q + cnt_t'(1);
        end
    end

    // R4: the step index stays inside the six-entry table
    a_r4_step_range: assert property (@(posedge clk) disable iff (rst)
        int'(step_q) < STEPS);

    // R5: the final boundary returns the counter to zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (fire && step_q == LAST_STEP) |=> (cnt_q == 0 && step_q == 0));

    // R6: a write restarts at step 0 with a negative count
    a_r6_restart_step0: assert property (@(posedge clk) disable iff (rst)
        (restart && !rst) |=> (step_q == 0 && cnt_q < 0));

endmodule

// File: rtl/fseq_irq.sv
module fseq_irq
    import fseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fcfg_t cfg,
    input  logic  fire,
    input  step_t step,
    input  logic  clr_wr,
    input  logic  ack,
    output logic  irq
);

    logic irq_q;
    logic set;

    always_comb begin
        set = fire && !cfg.five && !cfg.inhibit && step_raises_irq(step);
        irq = irq_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         irq_q <= 1'b0;
        else if (clr_wr) irq_q <= 1'b0;
        else if (set)    irq_q <= 1'b1;
        else if (ack)    irq_q <= 1'b0;
    end

    // R9: a masking write drops the level
    a_r9_mask_clears: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> !irq_q);

    // R11: the level only rises in unmasked 4-step mode
    a_r11_rise_needs_short_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(!cfg.five && !cfg.inhibit));

endmodule

// File: rtl/fseq_pulse.sv
module fseq_pulse
    import fseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  step_t step,
    input  logic  imm,
    output logic  qtr,
    output logic  half
);

    fev_e ev;
    logic qtr_q, half_q;

    always_comb begin
        ev   = step_event(step);
        qtr  = qtr_q;
        half = half_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qtr_q  <= 1'b0;
            half_q <= 1'b0;
        end else begin
            qtr_q  <= imm || (fire && ev != EV_NONE);
            half_q <= imm || (fire && ev == EV_HALF);
        end
    end

    // R4: a half-frame clock always brings a quarter-frame clock with it
    a_r4_half_has_qtr: assert property (@(posedge clk) disable iff (rst)
        half_q |-> qtr_q);

    // R7: a mode-5 write clocks both units in the next cycle
    a_r7_imm_clock: assert property (@(posedge clk) disable iff (rst)
        (imm && !rst) |=> (qtr_q && half_q));

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import fseq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int MODE_BIT    = 7,
    parameter int INH_BIT     = 6,
    parameter int ODD_DELAY   = 3,
    parameter int EVEN_DELAY  = 4,
    parameter int POWERUP_CNT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              region_pal,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cyc_odd,
    input  logic              irq_ack,
    output logic              qtr_pulse,
    output logic              half_pulse,
    output logic              irq
);

    fcfg_t cfg;
    logic  restart, imm_clk, irq_clr, fire;
    cnt_t  restart_val;
    step_t step;

    fseq_ctrl #(
        .DATA_W    (DATA_W),
        .MODE_BIT  (MODE_BIT),
        .INH_BIT   (INH_BIT),
        .ODD_DELAY (ODD_DELAY),
        .EVEN_DELAY(EVEN_DELAY)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .region_pal (region_pal),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cyc_odd    (cyc_odd),
        .cfg        (cfg),
        .restart    (restart),
        .restart_val(restart_val),
        .imm_clk    (imm_clk),
        .irq_clr    (irq_clr)
    );

    fseq_timer #(
        .POWERUP_CNT(POWERUP_CNT)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .restart    (restart),
        .restart_val(restart_val),
        .fire       (fire),
        .step       (step)
    );

    fseq_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .fire  (fire),
        .step  (step),
        .clr_wr(irq_clr),
        .ack   (irq_ack),
        .irq   (irq)
    );

    fseq_pulse u_pulse (
        .clk (clk),
        .rst (rst),
        .fire(fire),
        .step(step),
        .imm (imm_clk),
        .qtr (qtr_pulse),
        .half(half_pulse)
    );

endmodule

// File: tb/test_frame_sequencer.sv
module test_frame_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst, soft_rst, region_pal, wr_en, cyc_odd, irq_ack;
    logic [7:0] wr_data;
    logic       qtr_pulse, half_pulse, irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_sequencer i_frame_sequencer (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .region_pal(region_pal),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cyc_odd   (cyc_odd),
        .irq_ack   (irq_ack),
        .qtr_pulse (qtr_pulse),
        .half_pulse(half_pulse),
        .irq       (irq)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Boundary tables taken from R2 and R3
    function automatic int bnd(bit pal, bit five, int s);
        int t4 [6];
        int t5 [6];
        if (pal) begin
            t4 = '{8313, 16627, 24939, 33252, 33253, 33254};
            t5 = '{8313, 16627, 24939, 33253, 41565, 41566};
        end else begin
            t4 = '{7457, 14913, 22371, 29828, 29829, 29830};
            t5 = '{7457, 14913, 22371, 29829, 37281, 37282};
        end
        return five ? t5[s] : t4[s];
    endfunction

    // R4 event kinds: 0 none, 1 quarter, 2 half
    function automatic int evk(int s);
        if (s == 1 || s == 4) return 2;
        if (s == 0 || s == 2) return 1;
        return 0;
    endfunction

    // Caller has set up a reset or write at a falling edge; t=0 is the
    // sample after the next rising edge. Boundary B fires at t = B + off.
    task automatic run_frame(bit pal, bit five, int off, bit wrap, bit exp_irq,
                             bit imm, bit from_reset, string ev_req, string irq_req);
        int t_last  = bnd(pal, five, 5) + off;
        int t_wrap  = t_last + bnd(pal, five, 0) + 1;
        int t_end   = (wrap ? t_wrap : t_last) + 2;
        int t_irq   = bnd(pal, five, 3) + off;
        int extra   = 0;
        for (int t = 0; t <= t_end; t++) begin
            bit eq, eh, expect_ev;
            @(negedge clk);
            if (t == 0) begin
                wr_en    = 1'b0;
                rst      = 1'b0;
                soft_rst = 1'b0;
            end
            eq = 0; eh = 0; expect_ev = 0;
            if (imm && t == 0) begin
                expect_ev = 1; eq = 1; eh = 1;
            end
            for (int s = 0; s < 6; s++) begin
                if (t == bnd(pal, five, s) + off) begin
                    expect_ev = 1;
                    eq = (evk(s) != 0);
                    eh = (evk(s) == 2);
                end
            end
            if (wrap && t == t_wrap) begin
                expect_ev = 1; eq = 1; eh = 0;
            end
            if (expect_ev && (eq || eh)) begin
                check(qtr_pulse == eq, ev_req, "R4 quarter pulse at boundary", int'(qtr_pulse), int'(eq));
                check(half_pulse == eh, ev_req, "R4 half pulse at boundary", int'(half_pulse), int'(eh));
            end else if (qtr_pulse || half_pulse) begin
                extra++;
            end
            if (wrap && t == t_wrap) begin
                check(qtr_pulse && !half_pulse, "R5", "first boundary after wrap", int'(qtr_pulse), 1);
            end
            if (t == 0) begin
                check(irq == 1'b0, irq_req, "irq after start", int'(irq), 0);
                if (from_reset)
                    check(!qtr_pulse && !half_pulse, "R1", "pulses in reset state",
                          int'(qtr_pulse) + int'(half_pulse), 0);
            end
            if (t == t_irq - 1)
                check(irq == 1'b0, irq_req, "irq before step 3", int'(irq), 0);
            if (t == t_irq)
                check(irq == exp_irq, irq_req, "irq at step 3 boundary", int'(irq), int'(exp_irq));
            if (t == t_end)
                check(irq == exp_irq, irq_req, "irq held at frame end", int'(irq), int'(exp_irq));
        end
        check(extra == 0, ev_req, "stray pulses in frame", extra, 0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; soft_rst = 1'b0; region_pal = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00; cyc_odd = 1'b0; irq_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R1 R2 R5 R8: power-up, short region table, wrap into next frame
        run_frame(0, 0, -5, 1, 1, 0, 1, "R1 R2", "R8");

        // R9 R6: masking write on an odd cycle, irq drops and stays low
        wr_data = 8'h40; cyc_odd = 1'b1; wr_en = 1'b1;
        run_frame(0, 0, 4, 0, 0, 0, 0, "R6 R2", "R9");

        // R7 R6 R11 R3: 5-step write on an even cycle; region change ignored
        region_pal = 1'b1;
        wr_data = 8'h80; cyc_odd = 1'b0; wr_en = 1'b1;
        run_frame(0, 1, 5, 0, 0, 1, 0, "R7 R6 R3", "R11");

        // R12 R3: soft reset keeps 5-step mode, picks up the long table
        rst = 1'b1; soft_rst = 1'b1;
        run_frame(1, 1, -5, 0, 0, 0, 1, "R12 R3", "R12");

        // R12 R3 R8: hard reset returns to 4-step on the long table
        rst = 1'b1; soft_rst = 1'b0;
        run_frame(1, 0, -5, 0, 1, 0, 1, "R12 R3", "R8");

        // R10: acknowledge clears the level
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq == 1'b0, "R10", "irq after acknowledge", int'(irq), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule